// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable behavioural model of a synchronous static RAM whose read path is flow-through. The default array is 1024 words of 36 bits, split into four 9-bit byte lanes. On each rising clock edge the block captures the address, the chip selects, the write controls and the write data. In the cycle that follows the edge, the word at the captured address is on the output. No output register stage sits between the array and the output.

A cycle with `start_n` low opens an access. It samples the three chip selects, loads a base address and clears a 2-bit burst counter. Each later cycle with `adv_n` low steps the counter, and the two low address bits then follow either a linear (wrapping add) order or an interleaved (XOR) order. The order is latched when the access opens.

The write controls decide what each cycle does. A cycle with any lane selected for writing is a write. A write captured at one edge is stored in the array at the next edge, and the output is off for that whole cycle. The output enable acts asynchronously on the output-valid flag, which stands in for a tri-state driver.

A high `sleep` input freezes every register and blocks array writes, so all contents and the burst position survive. While `sleep` is high the output is off. Normal operation resumes once `sleep` is low again.

Top module: `fts_sram`

## Requirements
- R1: While `rst_n` is low and after it rises, `dout_en` stays 0 until a cycle with `start_n` low has selected the device.
- R2: A read captured at a rising edge has the word at the effective address on `dout` during the following cycle, with `dout_en`=1 when `out_en_n`=0.
  - A read is a selected cycle with no lane chosen for writing.
- R3: With `glob_wr_n`=0, all four lanes of `din` are written, whatever `byte_wr_n` and `lane_wr_n` hold.
- R4: With `glob_wr_n`=1 and `byte_wr_n`=0, only the lanes i with `lane_wr_n[i]`=0 are written. Lane i is bits [9i+8:9i].
  - With both `glob_wr_n` and `byte_wr_n` high, the cycle is a read.
- R5: A `start_n`=0 cycle selects the device only if `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0.
  - Otherwise the device stays deselected until the next such cycle. While deselected, nothing is written and `dout_en`=0.
- R6: With `burst_lin`=1 latched at start, the effective address low two bits are (base + n) mod 4 after n advance cycles. The upper bits hold the base.
- R7: With `burst_lin`=0 latched at start, the low two bits are base XOR n.
- R8: A cycle with `start_n`=1 and `adv_n`=1 keeps the effective address unchanged.
- R9: `out_en_n`=1 forces `dout_en` to 0 at once, without waiting for a clock edge.
- R10: During the cycle after a write is captured, `dout_en`=0.
- R11: While `sleep`=1, `dout_en`=0. No edge changes the registered address, the burst position, the selection or the array. After `sleep` returns to 0, operation continues from the frozen state.
- R12: A write captured at edge k is stored at edge k+1. A read of the same address captured at edge k+1 returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep | input | 1 | Freeze all activity and keep contents, active high |
| sel_a_n | input | 1 | Chip select A, active low |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| start_n | input | 1 | Start an access: sample selects and load address, active low |
| adv_n | input | 1 | Step the burst counter, active low |
| burst_lin | input | 1 | Burst order latched at start: 1 linear, 0 interleaved |
| glob_wr_n | input | 1 | Write all lanes, active low |
| byte_wr_n | input | 1 | Qualify per-lane write enables, active low |
| lane_wr_n | input | 4 | Per-lane write enables, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| addr | input | 10 | Word address |
| din | input | 36 | Write data |
| dout | output | 36 | Read data, zero when not enabled |
| dout_en | output | 1 | Output driven (valid) flag |

## Verification
Register-dependent results are due in the cycle right after the capturing edge:
- read data and `dout_en` for R2;
- the output-off state of a write cycle for R10;
- deselection for R5;
- the burst position for R6, R7 and R8.

A write shows in the array one edge later still, so it is seen through a read that is captured at or after that edge (R12). The bench updates its reference at each rising edge, then compares one time unit later, before it drives the next inputs.

`out_en_n` and `sleep` act combinationally on the output. They are checked a time unit after being changed in mid-cycle (R9, R11).

// File: rtl/fts_sram_pkg.sv
package fts_sram_pkg;

  // Low two address bits of a burst, given base bits, step count and order
  function automatic logic [1:0] burst_low(input logic [1:0] base_lo,
                                           input logic [1:0] step,
                                           input logic       linear);
    if (linear) return base_lo + step;
    else        return base_lo ^ step;
  endfunction

  // Selection requires all three chip selects in their active state
  function automatic logic chip_selected(input logic a_n, input logic b,
                                         input logic c_n);
    return !a_n && b && !c_n;
  endfunction

endpackage

// File: rtl/fts_burst_addr.sv
module fts_burst_addr
  import fts_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              start_n,
  input  logic              adv_n,
  input  logic              chip_ok,
  input  logic              burst_lin,
  input  logic [ADDR_W-1:0] addr,
  output logic              sel_next,
  output logic              sel_q,
  output logic [1:0]        cnt_q,
  output logic [ADDR_W-1:0] eff_addr
);

  logic [ADDR_W-1:0] base_q;
  logic              lin_q;

  always_comb sel_next = start_n ? sel_q : chip_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      base_q <= '0;
      cnt_q  <= 2'd0;
      lin_q  <= 1'b0;
    end else if (!hold) begin
      sel_q <= sel_next;
      if (!start_n) begin
        base_q <= addr;
        cnt_q  <= 2'd0;
        lin_q  <= burst_lin;
      end else if (!adv_n) begin
        cnt_q <= cnt_q + 2'd1;
      end
    end
  end

  assign eff_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_q, lin_q)};

endmodule

// File: rtl/fts_wr_ctl.sv
module fts_wr_ctl #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              sel_next,
  input  logic              glob_wr_n,
  input  logic              byte_wr_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic [DATA_W-1:0] din,
  output logic [LANES-1:0]  mask_q,
  output logic [DATA_W-1:0] data_q,
  output logic              wr_active
);

  // Global write wins; else the byte-write strobe qualifies the lane enables
  function automatic logic [LANES-1:0] lane_pick(input logic g_n, input logic b_n,
                                                 input logic [LANES-1:0] l_n);
    if (!g_n)      return '1;
    else if (!b_n) return ~l_n;
    else           return '0;
  endfunction

  logic [LANES-1:0] lanes_req;
  assign lanes_req = lane_pick(glob_wr_n, byte_wr_n, lane_wr_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      data_q <= '0;
    end else if (!hold) begin
      mask_q <= sel_next ? lanes_req : '0;
      data_q <= din;
    end
  end

  assign wr_active = |mask_q;

endmodule

// File: rtl/fts_array.sv
module fts_array #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic [LANES-1:0]  we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we[l]) mem[addr] <= wdata[l*LANE_W +: LANE_W];
    end
    assign rdata[l*LANE_W +: LANE_W] = mem[addr];
  end

endmodule

// File: rtl/fts_sram.sv
module fts_sram
  import fts_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              start_n,
  input  logic              adv_n,
  input  logic              burst_lin,
  input  logic              glob_wr_n,
  input  logic              byte_wr_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic              out_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  logic              chip_ok;
  logic              sel_next;
  logic              sel_q;
  logic [1:0]        cnt_q;
  logic [ADDR_W-1:0] eff_addr;
  logic [LANES-1:0]  mask_q;
  logic [DATA_W-1:0] data_q;
  logic              wr_active;
  logic [LANES-1:0]  commit_mask;
  logic [DATA_W-1:0] rdata;

  assign chip_ok = chip_selected(sel_a_n, sel_b, sel_c_n);

  fts_burst_addr #(.ADDR_W(ADDR_W)) burst_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (sleep),
    .start_n  (start_n),
    .adv_n    (adv_n),
    .chip_ok  (chip_ok),
    .burst_lin(burst_lin),
    .addr     (addr),
    .sel_next (sel_next),
    .sel_q    (sel_q),
    .cnt_q    (cnt_q),
    .eff_addr (eff_addr)
  );

  fts_wr_ctl #(.LANES(LANES), .LANE_W(LANE_W)) wr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (sleep),
    .sel_next (sel_next),
    .glob_wr_n(glob_wr_n),
    .byte_wr_n(byte_wr_n),
    .lane_wr_n(lane_wr_n),
    .din      (din),
    .mask_q   (mask_q),
    .data_q   (data_q),
    .wr_active(wr_active)
  );

  // A registered write lands at the next edge unless the block is asleep
  assign commit_mask = mask_q & {LANES{~sleep}};

  fts_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) array_i (
    .clk  (clk),
    .we   (commit_mask),
    .addr (eff_addr),
    .wdata(data_q),
    .rdata(rdata)
  );

  assign dout_en = sel_q && !wr_active && !out_en_n && !sleep;
  assign dout    = rdata & {DATA_W{dout_en}};

endmodule

// File: rtl/fts_sram_chk.sv
module fts_sram_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep,
  input logic              start_n,
  input logic              adv_n,
  input logic              chip_ok,
  input logic              sel_q,
  input logic              wr_active,
  input logic              dout_en,
  input logic              out_en_n,
  input logic [1:0]        cnt_q,
  input logic [ADDR_W-1:0] eff_addr
);

  assert_write_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_active |-> !dout_en);

  assert_out_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !dout_en);

  assert_deselect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !start_n && !chip_ok) |=> (!sel_q && !wr_active));

  assert_sleep_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dout_en);

  assert_sleep_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ($stable(eff_addr) && $stable(sel_q) && $stable(wr_active)));

  assert_burst_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && start_n && !adv_n) |=> (cnt_q == 2'($past(cnt_q) + 2'd1)));

  assert_burst_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !start_n) |=> (cnt_q == 2'd0));

  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && start_n && adv_n) |=> $stable(eff_addr));

endmodule

bind fts_sram fts_sram_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .sleep    (sleep),
  .start_n  (start_n),
  .adv_n    (adv_n),
  .chip_ok  (chip_ok),
  .sel_q    (sel_q),
  .wr_active(wr_active),
  .dout_en  (dout_en),
  .out_en_n (out_en_n),
  .cnt_q    (cnt_q),
  .eff_addr (eff_addr)
);

// File: tb/fts_sram_tb_top.sv
`timescale 1ns/1ps
module fts_sram_tb_top;

  localparam int AW = 10;
  localparam int DW = 36;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep = 1'b0;
  logic sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
  logic start_n = 1'b1, adv_n = 1'b1, burst_lin = 1'b1;
  logic glob_wr_n = 1'b1, byte_wr_n = 1'b1;
  logic [3:0] lane_wr_n = 4'hF;
  logic out_en_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en;

  always #5 clk = ~clk;

  fts_sram dut_i (
    .clk(clk), .rst_n(rst_n), .sleep(sleep),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .start_n(start_n), .adv_n(adv_n), .burst_lin(burst_lin),
    .glob_wr_n(glob_wr_n), .byte_wr_n(byte_wr_n), .lane_wr_n(lane_wr_n),
    .out_en_n(out_en_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";

  // Behavioural reference
  logic [DW-1:0] ref_mem [NW];
  bit m_sel = 0, m_lin = 0;
  int m_base = 0, m_cnt = 0;
  bit [3:0] m_mask = 0;
  logic [DW-1:0] m_dq = '0;

  function automatic int ref_addr();
    int lo;
    lo = m_lin ? ((m_base + m_cnt) % 4) : ((m_base % 4) ^ m_cnt);
    return (m_base / 4) * 4 + lo;
  endfunction

  function automatic logic [DW-1:0] pat(int a);
    return DW'(a) * 36'd2654435 ^ 36'h5A5A5A5A5;
  endfunction

  task automatic check1(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit exp_en;
    exp_en = rst_n && m_sel && (m_mask == 0) && !out_en_n && !sleep;
    check1(cur_req, DW'(dout_en), DW'(exp_en));
    if (exp_en) check1(cur_req, dout, ref_mem[ref_addr()]);
  endtask

  // One rising edge: update reference from inputs held across the edge
  task automatic step();
    bit cs, snext;
    bit [3:0] lanes;
    @(posedge clk);
    if (!rst_n) begin
      m_sel = 0; m_base = 0; m_cnt = 0; m_mask = 0; m_lin = 0;
    end else if (!sleep) begin
      if (m_mask != 0) begin
        int a;
        a = ref_addr();
        for (int l = 0; l < 4; l++)
          if (m_mask[l]) ref_mem[a][l*9 +: 9] = m_dq[l*9 +: 9];
      end
      cs = (sel_a_n == 0) && (sel_b == 1) && (sel_c_n == 0);
      snext = start_n ? m_sel : cs;
      if (!glob_wr_n) lanes = 4'hF;
      else if (!byte_wr_n) lanes = ~lane_wr_n;
      else lanes = 4'h0;
      if (!start_n) begin
        m_base = int'(addr); m_cnt = 0; m_lin = burst_lin;
      end else if (!adv_n) m_cnt = (m_cnt + 1) % 4;
      m_mask = snext ? lanes : 4'h0;
      m_dq = din;
      m_sel = snext;
    end
    #1;
    compare();
  endtask

  task automatic set_idle();
    start_n = 1; adv_n = 1; glob_wr_n = 1; byte_wr_n = 1; lane_wr_n = 4'hF;
  endtask

  task automatic select_ok();
    sel_a_n = 0; sel_b = 1; sel_c_n = 0;
  endtask

  task automatic open_rd(int a, bit lin);
    set_idle(); select_ok(); start_n = 0; addr = AW'(a); burst_lin = lin;
    step();
  endtask

  task automatic open_wr(int a, logic [DW-1:0] d, bit lin);
    set_idle(); select_ok(); start_n = 0; addr = AW'(a); burst_lin = lin;
    glob_wr_n = 0; din = d;
    step();
  endtask

  bit finished = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset and post-reset quiet output
    cur_req = "R1";
    repeat (3) step();
    rst_n = 1;
    repeat (3) step();

    // Preload every word with global writes; lane enables set to "none" are ignored (R3)
    cur_req = "R3";
    for (int a = 0; a < NW; a++) begin
      set_idle(); select_ok(); start_n = 0; addr = AW'(a);
      glob_wr_n = 0; byte_wr_n = 0; lane_wr_n = 4'hF; din = pat(a);
      step();
    end

    // R2: flow-through reads at several addresses
    cur_req = "R2";
    open_rd(5, 1); open_rd(1023, 1); open_rd(0, 1); open_rd(512, 1);

    // R4: byte write lanes 0 and 2 only
    cur_req = "R4";
    set_idle(); select_ok(); start_n = 0; addr = 10'd5;
    byte_wr_n = 0; lane_wr_n = 4'b1010; din = 36'h0;
    step();
    open_rd(5, 1);
    // byte strobe with no lane chosen is a read
    set_idle(); select_ok(); start_n = 0; addr = 10'd5;
    byte_wr_n = 0; lane_wr_n = 4'hF; din = '1;
    step();
    step();

    // R3: global write overrides a single-lane choice
    cur_req = "R3";
    set_idle(); select_ok(); start_n = 0; addr = 10'd6;
    glob_wr_n = 0; byte_wr_n = 0; lane_wr_n = 4'b1110; din = 36'hABCDE1234;
    step();
    open_rd(6, 1);

    // R5: each select alone wrong blocks a write and the output
    cur_req = "R5";
    for (int k = 0; k < 3; k++) begin
      set_idle(); select_ok(); start_n = 0; addr = 10'd7;
      glob_wr_n = 0; din = 36'h111111111;
      if (k == 0) sel_a_n = 1;
      if (k == 1) sel_b = 0;
      if (k == 2) sel_c_n = 1;
      step();
      set_idle(); adv_n = 0; glob_wr_n = 0; step();  // continue while deselected
    end
    open_rd(7, 1);

    // R12: write then read the same word on the very next edge
    cur_req = "R12";
    open_wr(9, 36'h0F0F0F0F0, 1);
    open_rd(9, 1);

    // R6: linear burst writes from base 10, then read back
    cur_req = "R6";
    open_wr(10, 36'h100000001, 1);
    for (int n = 1; n < 4; n++) begin
      set_idle(); adv_n = 0; glob_wr_n = 0; din = DW'(36'h100000001 + n); step();
    end
    open_rd(10, 1);
    for (int n = 0; n < 5; n++) begin set_idle(); adv_n = 0; step(); end

    // R7: interleaved reads from base 13
    cur_req = "R7";
    open_rd(13, 0);
    for (int n = 0; n < 5; n++) begin set_idle(); adv_n = 0; step(); end
    open_wr(14, 36'h222222222, 0);
    set_idle(); adv_n = 0; glob_wr_n = 0; din = 36'h333333333; step();
    open_rd(15, 0);
    set_idle(); adv_n = 0; step();

    // R8: hold without advance
    cur_req = "R8";
    open_rd(21, 1);
    set_idle(); adv_n = 0; step();
    set_idle(); step(); step();

    // R9: output enable acts without a clock edge
    cur_req = "R9";
    out_en_n = 1; #1; compare();
    out_en_n = 0; #1; compare();
    out_en_n = 1; step(); out_en_n = 0; #1; compare();

    // R10: output off during write cycles
    cur_req = "R10";
    open_wr(30, 36'h444444444, 1);
    open_wr(31, 36'h555555555, 1);
    open_rd(30, 1);

    // R11: sleep freezes state, blocks writes and turns off the output
    cur_req = "R11";
    open_rd(40, 1);
    set_idle(); adv_n = 0; step();
    sleep = 1; #1; compare();
    for (int n = 0; n < 3; n++) begin
      set_idle(); select_ok(); start_n = 0; addr = 10'd41; glob_wr_n = 0;
      din = 36'h999999999; adv_n = 0;
      step();
    end
    set_idle(); sleep = 0; #1; compare();
    step();
    adv_n = 0; step(); step();
    open_rd(41, 1);
    // a write registered just before sleep lands after waking
    open_wr(50, 36'h777777777, 1);
    set_idle(); sleep = 1; step(); step();
    sleep = 0; step();
    open_rd(50, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule